// File: doc/BRIEF.md
# Four-Lane Marker-Aligned Deskew Stage

This stage sits on the receive side of a striped link. Four physical lanes arrive on one clock, and each carries a stream of 66-bit blocks with its own valid bit. Each lane periodically replaces one data block with an alignment marker. The marker has a fixed pattern, and its low byte names the logical lane that the stream belongs to. A tracker on each lane locks to the marker cadence and records the logical lane number.

Each lane writes into its own 32-entry FIFO. The read side discards blocks on every lane until each FIFO head holds a marker. The first lanes to reach a marker hold there, which delays them until the slowest lane catches up. When all heads are markers, the markers are popped together and dropped. From then on the FIFOs are read in lockstep. Each output row is reordered so that output slot k carries logical lane k.

At every later marker position the heads are checked again. If the markers no longer coincide on all lanes, the stage drops alignment and realigns on a later marker. If a lane's skew exceeds the FIFO depth, a sticky error flag is raised.

Top module: `am_lane_deskew`

## Requirements
- R1: While reset is held low, `out_valid`, `all_aligned`, `deskew_err` and every bit of `lane_locked` are 0.
- R2: The marker for logical lane k is a 66-bit block with bits [65:64] = 2'b10, bits [63:8] = 56'h9E3F71C04AD2B5 and bits [7:0] = k. The lane number of a physical lane is taken from its marker.
- R3: A lane raises `lane_locked` on the valid block that is a second marker with the same lane number, arriving exactly AM_PERIOD valid blocks after the first one.
- R4: A locked lane stays locked through up to MAX_BAD-1 consecutive bad markers (default 4). A bad marker is a wrong or missing marker at an expected position. The lane drops lock on the MAX_BAD-th consecutive bad marker.
- R5: `all_aligned` can only rise after every lane was locked with a distinct lane number. If two physical lanes claim the same logical lane, no alignment and no output occur.
- R6: Every output row carries blocks that were sent at the same block index on all lanes, for any skew up to FIFO_DEPTH blocks. Rows leave in increasing index order.
- R7: Output slot k (`out_blocks[k*66 +: 66]`) carries logical lane k, whatever physical lane delivered it.
- R8: Marker blocks never appear on the output.
- R9: If a skew exceeds FIFO_DEPTH blocks, `deskew_err` is raised and alignment is not reached. `deskew_err` clears when alignment is next reached.
- R10: If the markers of an aligned stream stop coinciding on all lanes, the stage drops alignment and regains it at a later marker. Data ordering stays correct after the gap.
- R11: If any lane loses lock, `all_aligned` is 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | NLANES | Per physical lane: a block is present this cycle |
| rx_blocks | input | 66*NLANES | Physical lane p in bits [p*66 +: 66] |
| out_valid | output | 1 | An aligned output row is present |
| out_blocks | output | 66*NLANES | Logical lane k in bits [k*66 +: 66] |
| lane_locked | output | NLANES | Per physical lane: marker lock |
| all_aligned | output | 1 | All lanes are deskewed and streaming |
| deskew_err | output | 1 | Sticky: a skew exceeded the FIFO depth |

## Verification
The hardest conditions to reach from the ports are realignment after a few corrupted markers and lock loss after MAX_BAD of them. Both need a lane that is already locked and aligned, followed by bad markers on consecutive marker periods. The bench builds every lane stream from a block index. It then swaps chosen markers for ordinary data blocks on one lane, over a chosen range of marker periods. Around these directed cases it shuffles the lane order and draws per-lane skews and common stall cycles from a seeded random source, and it checks each output row by decoding its block index.

// File: rtl/am_deskew_pkg.sv
package am_deskew_pkg;
    localparam int BLK_W = 66;
    localparam logic [1:0]  HDR_CTRL = 2'b10;
    localparam logic [55:0] AM_BODY  = 56'h9E3F71C04AD2B5;

    typedef enum logic [1:0] {
        DS_HUNT,
        DS_ARM,
        DS_ALIGN,
        DS_RUN
    } deskew_state_e;

    typedef enum logic [1:0] {
        TR_SEARCH,
        TR_CHECK,
        TR_LOCKED
    } track_state_e;
endpackage

// File: rtl/am_lane_tracker.sv
module am_lane_tracker
    import am_deskew_pkg::*;
#(
    parameter int NLANES    = 4,
    parameter int AM_PERIOD = 16384,
    parameter int MAX_BAD   = 4,
    localparam int IDW  = (NLANES > 1) ? $clog2(NLANES) : 1,
    localparam int CW   = $clog2(AM_PERIOD),
    localparam int BADW = $clog2(MAX_BAD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_valid,
    input  logic [BLK_W-1:0] blk,
    output logic             locked,
    output logic [IDW-1:0]   lane_id,
    output logic             am_hit
);
    track_state_e   st, st_n;
    logic [CW-1:0]  cnt, cnt_n;
    logic [IDW-1:0] id_q, id_n;
    logic [BADW-1:0] bad, bad_n;
    logic is_am, at_exp, good;
    logic [IDW-1:0] found;

    always_comb begin
        is_am  = (blk[65:64] == HDR_CTRL) && (blk[63:8] == AM_BODY) &&
                 (blk[7:0] < 8'(NLANES));
        found  = blk[IDW-1:0];
        at_exp = (cnt == CW'(AM_PERIOD - 1));
        good   = is_am && (found == id_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= TR_SEARCH;
            cnt  <= '0;
            id_q <= '0;
            bad  <= '0;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            id_q <= id_n;
            bad  <= bad_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        id_n  = id_q;
        bad_n = bad;
        if (blk_valid) begin
            unique case (st)
                TR_SEARCH: begin
                    if (is_am) begin
                        st_n  = TR_CHECK;
                        cnt_n = '0;
                        id_n  = found;
                    end
                end
                TR_CHECK: begin
                    if (at_exp) begin
                        cnt_n = '0;
                        if (good) begin
                            st_n  = TR_LOCKED;
                            bad_n = '0;
                        end else begin
                            st_n = TR_SEARCH;
                        end
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                TR_LOCKED: begin
                    if (at_exp) begin
                        cnt_n = '0;
                        if (good) begin
                            bad_n = '0;
                        end else if (bad == BADW'(MAX_BAD - 1)) begin
                            st_n  = TR_SEARCH;
                            bad_n = '0;
                        end else begin
                            bad_n = bad + 1'b1;
                        end
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                default: st_n = TR_SEARCH;
            endcase
        end
    end

    always_comb begin
        locked  = (st == TR_LOCKED);
        lane_id = id_q;
        am_hit  = blk_valid && (st == TR_LOCKED) && at_exp && good;
    end
endmodule

// File: rtl/deskew_fifo.sv
module deskew_fifo #(
    parameter int W     = 67,
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   count;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr) wp <= wp + 1'b1;
            if (rd) rp <= rp + 1'b1;
            unique case ({wr, rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr && !flush) mem[wp] <= wdata;
    end

    always_comb begin
        rdata = mem[rp];
        empty = (count == '0);
        full  = (count == (AW+1)'(DEPTH));
    end
endmodule

// File: rtl/am_lane_deskew.sv
module am_lane_deskew
    import am_deskew_pkg::*;
#(
    parameter int NLANES     = 4,
    parameter int AM_PERIOD  = 16384,
    parameter int FIFO_DEPTH = 32,
    parameter int MAX_BAD    = 4,
    localparam int IDW = (NLANES > 1) ? $clog2(NLANES) : 1,
    localparam int QW  = $clog2(FIFO_DEPTH + 1),
    localparam int FW  = BLK_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NLANES-1:0]       rx_valid,
    input  logic [NLANES*BLK_W-1:0] rx_blocks,
    output logic                    out_valid,
    output logic [NLANES*BLK_W-1:0] out_blocks,
    output logic [NLANES-1:0]       lane_locked,
    output logic                    all_aligned,
    output logic                    deskew_err
);
    deskew_state_e st, st_n;
    logic          err_q;
    logic [QW-1:0] quiet;

    logic [IDW-1:0]    lane_id [NLANES];
    logic [NLANES-1:0] am_hit, wr, pop, empty, full, hflag;
    logic [FW-1:0]     head [NLANES];
    logic              flush, emit, ovf, open, all_ok, all_ne, all_fl, any_fl;
    logic [NLANES-1:0] id_seen;
    logic [NLANES*BLK_W-1:0] row;

    for (genvar p = 0; p < NLANES; p++) begin : g_lane
        am_lane_tracker #(
            .NLANES(NLANES), .AM_PERIOD(AM_PERIOD), .MAX_BAD(MAX_BAD)
        ) u_trk (
            .clk(clk), .rst_n(rst_n),
            .blk_valid(rx_valid[p]),
            .blk(rx_blocks[p*BLK_W +: BLK_W]),
            .locked(lane_locked[p]),
            .lane_id(lane_id[p]),
            .am_hit(am_hit[p])
        );
        deskew_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n), .flush(flush),
            .wr(wr[p]),
            .wdata({am_hit[p], rx_blocks[p*BLK_W +: BLK_W]}),
            .rd(pop[p]),
            .rdata(head[p]),
            .empty(empty[p]),
            .full(full[p])
        );
        assign hflag[p] = head[p][BLK_W];
    end

    always_comb begin
        id_seen = '0;
        for (int p = 0; p < NLANES; p++) id_seen[lane_id[p]] = 1'b1;
        all_ok = (&lane_locked) && (&id_seen);
        all_ne = ~|empty;
        all_fl = &hflag;
        any_fl = |hflag;
        open   = (st == DS_ARM) && all_ok && (|am_hit) &&
                 (quiet == QW'(FIFO_DEPTH));
        wr     = rx_valid & {NLANES{(st == DS_ALIGN) || (st == DS_RUN) || open}};
    end

    always_comb begin
        row = '0;
        for (int k = 0; k < NLANES; k++)
            for (int p = 0; p < NLANES; p++)
                if (lane_id[p] == IDW'(k))
                    row[k*BLK_W +: BLK_W] = head[p][BLK_W-1:0];
    end

    always_comb begin
        st_n  = st;
        pop   = '0;
        flush = 1'b0;
        emit  = 1'b0;
        unique case (st)
            DS_HUNT: begin
                flush = 1'b1;
                if (all_ok) st_n = DS_ARM;
            end
            DS_ARM: begin
                if (!all_ok) begin
                    st_n  = DS_HUNT;
                    flush = 1'b1;
                end else if (open) begin
                    st_n = DS_ALIGN;
                end else begin
                    flush = 1'b1;
                end
            end
            DS_ALIGN: begin
                pop = ~empty & ~hflag;
                if (all_ne && all_fl) begin
                    pop  = '1;
                    st_n = DS_RUN;
                end
            end
            DS_RUN: begin
                if (all_ne) begin
                    if (all_fl) begin
                        pop = '1;
                    end else if (!any_fl) begin
                        pop  = '1;
                        emit = 1'b1;
                    end else begin
                        st_n  = DS_ARM;
                        flush = 1'b1;
                    end
                end
            end
            default: st_n = DS_HUNT;
        endcase
        ovf = |(wr & full & ~pop);
        if ((st == DS_ALIGN) || (st == DS_RUN)) begin
            if (!all_ok) begin
                st_n  = DS_HUNT;
                flush = 1'b1;
                emit  = 1'b0;
            end else if (ovf) begin
                st_n  = DS_ARM;
                flush = 1'b1;
                emit  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= DS_HUNT;
            err_q <= 1'b0;
            quiet <= QW'(FIFO_DEPTH);
        end else begin
            st <= st_n;
            if (ovf && all_ok && ((st == DS_ALIGN) || (st == DS_RUN)))
                err_q <= 1'b1;
            else if ((st_n == DS_RUN) && (st != DS_RUN))
                err_q <= 1'b0;
            if (|am_hit)
                quiet <= '0;
            else if (quiet != QW'(FIFO_DEPTH))
                quiet <= quiet + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_blocks <= '0;
        end else begin
            out_valid <= emit;
            if (emit) out_blocks <= row;
        end
    end

    assign all_aligned = (st == DS_RUN);
    assign deskew_err  = err_q;
endmodule

// File: rtl/am_lane_deskew_sva.sv
module am_lane_deskew_sva #(
    parameter int NLANES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic [NLANES-1:0] lane_locked,
    input logic              all_aligned,
    input logic              deskew_err
);
    assert_out_needs_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(all_aligned));

    assert_align_after_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(all_aligned) |-> $past(&lane_locked));

    assert_unlock_drops_align_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(&lane_locked) |=> !all_aligned);

    assert_err_outside_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(deskew_err) |-> !all_aligned);

    assert_align_clears_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(all_aligned) |-> !deskew_err);
endmodule

bind am_lane_deskew am_lane_deskew_sva #(.NLANES(NLANES)) u_sva (
    .clk(clk),
    .rst_n(rst_n),
    .out_valid(out_valid),
    .lane_locked(lane_locked),
    .all_aligned(all_aligned),
    .deskew_err(deskew_err)
);

// File: tb/am_lane_deskew_bench.sv
module am_lane_deskew_bench;
    localparam int NL = 4;
    localparam int P  = 80;
    localparam int D  = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL-1:0]   rx_valid = '0;
    logic [NL*66-1:0] rx_blocks = '0;
    logic            out_valid;
    logic [NL*66-1:0] out_blocks;
    logic [NL-1:0]   lane_locked;
    logic            all_aligned;
    logic            deskew_err;

    am_lane_deskew #(.NLANES(NL), .AM_PERIOD(P), .FIFO_DEPTH(D)) u_am_lane_deskew (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_blocks(rx_blocks),
        .out_valid(out_valid), .out_blocks(out_blocks), .lane_locked(lane_locked),
        .all_aligned(all_aligned), .deskew_err(deskew_err)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int perm [NL];
    int skew [NL];
    int rows, jumps, order_err, lock_t, saw_aligned, saw_unlock, was_locked;
    int align_unlocked, row_err, am_out, prev_n, have_prev;
    bit prev_all_locked;

    function automatic logic [65:0] mk_data(int k, int n);
        return {2'b01, 8'(k), 24'(n), (32'(n) * 32'h9E3779B1) ^ 32'(k)};
    endfunction

    function automatic logic [65:0] mk_am(int k);
        return {2'b10, 56'h9E3F71C04AD2B5, 8'(k)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic sample();
        bit all_l;
        all_l = &lane_locked;
        if (all_l && lock_t < 0) lock_t = -2;
        if (all_l) was_locked = 1;
        if (was_locked && !all_l) saw_unlock = 1;
        if (all_aligned) saw_aligned = 1;
        if (all_aligned && !prev_all_locked) align_unlocked++;
        prev_all_locked = all_l;
        if (out_valid) begin
            int n;
            int miss;
            n = int'(out_blocks[55:32]);
            miss = 0;
            for (int k = 0; k < NL; k++)
                if (out_blocks[k*66 +: 66] != mk_data(k, n)) miss++;
            rows++;
            if (miss != 0) row_err++;
            if (n % P == 0) am_out++;
            if (have_prev != 0) begin
                if (n <= prev_n) order_err++;
                else if (!(n == prev_n + 1 || ((prev_n + 1) % P == 0 && n == prev_n + 2)))
                    jumps++;
            end
            have_prev = 1;
            prev_n = n;
        end
    endtask

    task automatic run_case(input int ncyc, input int stall_pct, input int bad_lane,
                            input int bad_from, input int bad_cnt);
        int t;
        rst_n = 1'b0;
        rx_valid = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && all_aligned == 0 && deskew_err == 0 && lane_locked == '0,
            "R1", "outputs in reset", {out_valid, all_aligned, deskew_err, lane_locked}, 0);
        rst_n = 1'b1;
        rows = 0; jumps = 0; order_err = 0; lock_t = -1; saw_aligned = 0;
        saw_unlock = 0; was_locked = 0; align_unlocked = 0; row_err = 0; am_out = 0;
        prev_n = 0; have_prev = 0; prev_all_locked = 1'b0;
        t = 0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            sample();
            if (lock_t == -2) lock_t = t;
            if (int'($urandom_range(99)) < stall_pct) begin
                rx_valid = '0;
            end else begin
                for (int p = 0; p < NL; p++) begin
                    int n;
                    n = t - skew[p];
                    rx_valid[p] = (n >= 0);
                    if (n < 0) rx_blocks[p*66 +: 66] = '0;
                    else if (n % P != 0) rx_blocks[p*66 +: 66] = mk_data(perm[p], n);
                    else if (p == bad_lane && n / P >= bad_from && n / P < bad_from + bad_cnt)
                        rx_blocks[p*66 +: 66] = mk_data(perm[p], n);
                    else rx_blocks[p*66 +: 66] = mk_am(perm[p]);
                end
                t++;
            end
        end
        @(negedge clk);
        sample();
        rx_valid = '0;
    endtask

    task automatic check_clean(input string tag);
        chk(&lane_locked, "R2", {tag, " all lanes locked"}, lane_locked, 4'hF);
        chk(all_aligned == 1, "R6", {tag, " aligned at end"}, all_aligned, 1);
        chk(rows > P * 5, "R6", {tag, " rows delivered"}, rows, P * 5);
        chk(row_err == 0, "R7", {tag, " rows with wrong lane content"}, row_err, 0);
        chk(jumps == 0 && order_err == 0, "R6", {tag, " index continuity"}, jumps + order_err, 0);
        chk(am_out == 0, "R8", {tag, " marker rows on output"}, am_out, 0);
        chk(deskew_err == 0, "R9", {tag, " no deskew error"}, deskew_err, 0);
    endtask

    initial begin
        void'($urandom(32'd715));

        // Directed: identity order, no skew
        for (int p = 0; p < NL; p++) begin perm[p] = p; skew[p] = 0; end
        run_case(900, 0, -1, 0, 0);
        check_clean("identity");
        chk(lock_t == P + 1, "R3", "lock after second marker", lock_t, P + 1);

        // Random orderings, skews and common stalls
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < NL; p++) begin perm[p] = p; skew[p] = int'($urandom_range(24)); end
            for (int i = NL - 1; i > 0; i--) begin
                int j, tmp;
                j = int'($urandom_range(i));
                tmp = perm[i]; perm[i] = perm[j]; perm[j] = tmp;
            end
            run_case(1150, 12, -1, 0, 0);
            check_clean("random");
        end

        // Duplicate logical lane number
        perm[0] = 0; perm[1] = 1; perm[2] = 1; perm[3] = 3;
        for (int p = 0; p < NL; p++) skew[p] = 0;
        run_case(700, 0, -1, 0, 0);
        chk(saw_aligned == 0, "R5", "aligned with duplicate lane numbers", saw_aligned, 0);
        chk(rows == 0, "R5", "rows with duplicate lane numbers", rows, 0);

        // Skew beyond FIFO depth
        perm[0] = 2; perm[1] = 0; perm[2] = 3; perm[3] = 1;
        skew[0] = 0; skew[1] = 0; skew[2] = 40; skew[3] = 0;
        run_case(800, 0, -1, 0, 0);
        chk(deskew_err == 1, "R9", "deskew error on large skew", deskew_err, 1);
        chk(saw_aligned == 0, "R9", "aligned despite large skew", saw_aligned, 0);

        // Three bad markers: lock kept, realignment
        perm[0] = 3; perm[1] = 2; perm[2] = 1; perm[3] = 0;
        skew[0] = 5; skew[1] = 0; skew[2] = 9; skew[3] = 2;
        run_case(1300, 0, 2, 6, 3);
        chk(saw_unlock == 0, "R4", "lock kept through three bad markers", saw_unlock, 0);
        chk(all_aligned == 1, "R10", "realigned after marker mismatch", all_aligned, 1);
        chk(jumps >= 1, "R10", "gap seen during realignment", jumps, 1);
        chk(row_err == 0 && order_err == 0, "R10", "rows correct around realignment",
            row_err + order_err, 0);
        chk(deskew_err == 0, "R9", "error cleared once aligned", deskew_err, 0);

        // Four bad markers: lock lost, then regained
        perm[0] = 1; perm[1] = 3; perm[2] = 0; perm[3] = 2;
        for (int p = 0; p < NL; p++) skew[p] = p * 3;
        run_case(1500, 0, 1, 6, 4);
        chk(saw_unlock == 1, "R4", "lock lost on fourth bad marker", saw_unlock, 1);
        chk(align_unlocked == 0, "R11", "aligned while a lane unlocked", align_unlocked, 0);
        chk(all_aligned == 1 && (&lane_locked), "R3", "relock and realign",
            {all_aligned, lane_locked}, 5'h1F);
        chk(row_err == 0 && am_out == 0, "R8", "rows correct after relock", row_err + am_out, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule